// File: doc/BRIEF.md
# Serial Controller Flag Register with Paired Set/Clear Requests

This block keeps the operating flags of a serial controller: the enable flag, the master-select flag and six error flags (transmit, receive, abort, transmit underflow, receive underflow, mode). Software never writes the flags directly. It writes a 16-bit request word in which every flag owns one clear bit and one set bit. A single write can therefore raise some flags and drop others in the same clock cycle, with no read-modify-write sequence. Error detectors outside the block pulse one-cycle event inputs, and each pulse sets the matching flag.

The block also holds a 4-bit interrupt enable register. It drives an error interrupt output. That output is high when the error line of the interrupt enable register is set and at least one error flag is set whose per-error enable from the controller's control register is also set. The serial engine lies outside the block. It supplies the busy indication and the error events.

Top module: `sflag_top`

## Requirements
- R1: After a synchronous active-low reset, the enable flag, the master-select flag, every error flag, the interrupt enable register and `err_irq` are all 0. Status bit 13 still shows `busy`.
- R2: A request write with `req_wr` high sets a flag one cycle later through its set bit. Set bits are: bit1 enable, bit3 master select, bit12 transmit error, bit13 receive error, bit14 abort error, bit15 transmit underflow, bit5 receive underflow, bit7 mode error. The flags appear in `status` at these positions: bit0 enable, bit1 master select, bit8 transmit error, bit9 receive error, bit10 abort error, bit11 transmit underflow, bit12 receive underflow, bit14 mode error. All other status bits except bit13 read 0.
- R3: A request write clears a flag through its clear bit. Clear bits are: bit0 enable, bit2 master select, bit8 transmit error, bit9 receive error, bit10 abort error, bit11 transmit underflow, bit4 receive underflow, bit6 mode error. If one write asks to set and to clear the same flag, the flag ends up cleared.
- R4: Writing the request word 0x0F50 clears every error flag and leaves enable and master select unchanged.
- R5: A pulse on `hw_err[i]` sets error flag i one cycle later. The order is: 0 transmit, 1 receive, 2 abort, 3 transmit underflow, 4 receive underflow, 5 mode. The pulse wins over a clear request for that flag in the same cycle.
- R6: While `busy` is high, a request to clear the enable flag is ignored. A set request for enable in the same write still takes effect.
- R7: Status bit 13 follows `busy` in the same cycle.
- R8: `err_irq` is high exactly when interrupt enable bit 2 is set and some error flag i is set with `err_en[i]` high. It is computed from the stored state with no added delay.
- R9: A write with `ien_wr` high loads `ien_data` into the interrupt enable register one cycle later. Its bits are: bit0 receive, bit1 transmit, bit2 error, bit3 frame end.
- R10: With `req_wr` low and no error event, every flag holds its value whatever `req_data` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_wr | input | 1 | Request word write strobe |
| req_data | input | 16 | Paired set/clear request word |
| ien_wr | input | 1 | Interrupt enable write strobe |
| ien_data | input | 4 | Interrupt enable write data |
| hw_err | input | 6 | One-cycle error events from the serial engine |
| err_en | input | 6 | Per-error interrupt enables from the control register |
| busy | input | 1 | Transfer in progress |
| status | output | 16 | Flag status word |
| ien | output | 4 | Interrupt enable register |
| err_irq | output | 1 | Error interrupt request |

## Verification
Every flag is a single register that `status` shows directly, so a wrong flag appears at the ports one cycle after the write or event that caused it. A wrong error flag also shows on `err_irq` in the same cycle, if its enables are on. The bench keeps its own model of the flags and compares `status`, `ien` and `err_irq` on every clock. Any priority error is seen at the first cycle where it matters: clear against set, event against clear, or busy against a clear of enable.

// File: rtl/sflag_pkg.sv
// Package: widths and bit positions shared by the flag register blocks.
// Assumes a 16-bit request word and a 16-bit status word.
package sflag_pkg;
    localparam int REQ_W  = 16;
    localparam int STAT_W = 16;
    localparam int NERR   = 6;
    localparam int IEN_W  = 4;

    // request word bit positions for the control flags
    localparam int EN_CLR_POS = 0;
    localparam int EN_SET_POS = 1;
    localparam int MS_CLR_POS = 2;
    localparam int MS_SET_POS = 3;

    // error index order: tx, rx, abort, tx-underflow, rx-underflow, mode
    localparam int ERR_CLR_POS [NERR] = '{8, 9, 10, 11, 4, 6};
    localparam int ERR_SET_POS [NERR] = '{12, 13, 14, 15, 5, 7};
    localparam int ERR_STAT_POS[NERR] = '{8, 9, 10, 11, 12, 14};

    localparam int STAT_EN_POS   = 0;
    localparam int STAT_MS_POS   = 1;
    localparam int STAT_BUSY_POS = 13;

    localparam int IEN_ERR_POS = 2;
endpackage

// File: rtl/sflag_decode.sv
// Module: splits a request write into per-flag set and clear strobes.
// Assumes the request word layout in sflag_pkg; purely combinational.
module sflag_decode
    import sflag_pkg::*;
(
    input  logic             wr,
    input  logic [REQ_W-1:0] word,
    output logic             en_set,
    output logic             en_clr,
    output logic             ms_set,
    output logic             ms_clr,
    output logic [NERR-1:0]  err_set,
    output logic [NERR-1:0]  err_clr
);
    // control flag strobes, gated by the write
    always_comb begin
        en_set = wr & word[EN_SET_POS];
        en_clr = wr & word[EN_CLR_POS];
        ms_set = wr & word[MS_SET_POS];
        ms_clr = wr & word[MS_CLR_POS];
    end

    for (genvar i = 0; i < NERR; i++) begin : g_err
        // error flag strobes at their own positions
        always_comb begin
            err_set[i] = wr & word[ERR_SET_POS[i]];
            err_clr[i] = wr & word[ERR_CLR_POS[i]];
        end
    end
endmodule

// File: rtl/sflag_bank.sv
// Module: holds enable, master-select and error flags.
// Priority per error flag: hardware event, then clear, then set.
// Enable clear is held off while busy. Assumes strobes are already decoded.
module sflag_bank
    import sflag_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_set,
    input  logic            en_clr,
    input  logic            ms_set,
    input  logic            ms_clr,
    input  logic [NERR-1:0] err_set,
    input  logic [NERR-1:0] err_clr,
    input  logic [NERR-1:0] hw_err,
    input  logic            busy,
    output logic            en_q,
    output logic            ms_q,
    output logic [NERR-1:0] err_q
);
    logic en_clr_ok;

    // a clear of enable only counts when no transfer is running
    always_comb en_clr_ok = en_clr & ~busy;

    // enable flag register
    always_ff @(posedge clk) begin
        if (!rst_n)         en_q <= 1'b0;
        else if (en_clr_ok) en_q <= 1'b0;
        else if (en_set)    en_q <= 1'b1;
    end

    // master-select flag register
    always_ff @(posedge clk) begin
        if (!rst_n)      ms_q <= 1'b0;
        else if (ms_clr) ms_q <= 1'b0;
        else if (ms_set) ms_q <= 1'b1;
    end

    for (genvar i = 0; i < NERR; i++) begin : g_flag
        // one error flag: event beats clear beats set
        always_ff @(posedge clk) begin
            if (!rst_n)          err_q[i] <= 1'b0;
            else if (hw_err[i])  err_q[i] <= 1'b1;
            else if (err_clr[i]) err_q[i] <= 1'b0;
            else if (err_set[i]) err_q[i] <= 1'b1;
        end

        // R5
        hw_event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hw_err[i] |=> err_q[i]);

        // R3
        clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (err_clr[i] && !hw_err[i]) |=> !err_q[i]);

        // R10
        err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!err_clr[i] && !err_set[i] && !hw_err[i]) |=> $stable(err_q[i]));
    end

    // R6
    busy_keeps_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && en_q) |=> en_q);

    // R3
    ms_clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ms_clr |=> !ms_q);
endmodule

// File: rtl/sflag_irq.sv
// Module: interrupt enable register and error interrupt output.
// Assumes err_en comes from the controller's control register.
module sflag_irq
    import sflag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ien_wr,
    input  logic [IEN_W-1:0] ien_data,
    input  logic [NERR-1:0]  err_q,
    input  logic [NERR-1:0]  err_en,
    output logic [IEN_W-1:0] ien_q,
    output logic             err_irq
);
    // interrupt enable register
    always_ff @(posedge clk) begin
        if (!rst_n)      ien_q <= '0;
        else if (ien_wr) ien_q <= ien_data;
    end

    // error interrupt from stored flags, masked per source and globally
    always_comb err_irq = ien_q[IEN_ERR_POS] & (|(err_q & err_en));

    // R8
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_q[IEN_ERR_POS] |-> !err_irq);

    // R9
    ien_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ien_wr |=> (ien_q == $past(ien_data)));
endmodule

// File: rtl/sflag_top.sv
// Module: flag register for a serial controller with paired set/clear
// requests, hardware error events and an error interrupt.
// Assumes hw_err pulses are synchronous to clk.
module sflag_top
    import sflag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_wr,
    input  logic [15:0]       req_data,
    input  logic              ien_wr,
    input  logic [3:0]        ien_data,
    input  logic [5:0]        hw_err,
    input  logic [5:0]        err_en,
    input  logic              busy,
    output logic [15:0]       status,
    output logic [3:0]        ien,
    output logic              err_irq
);
    logic            en_set, en_clr, ms_set, ms_clr;
    logic [NERR-1:0] err_set, err_clr, err_q;
    logic            en_q, ms_q;

    sflag_decode u_dec (
        .wr(req_wr), .word(req_data),
        .en_set(en_set), .en_clr(en_clr), .ms_set(ms_set), .ms_clr(ms_clr),
        .err_set(err_set), .err_clr(err_clr)
    );

    sflag_bank u_bank (
        .clk(clk), .rst_n(rst_n),
        .en_set(en_set), .en_clr(en_clr), .ms_set(ms_set), .ms_clr(ms_clr),
        .err_set(err_set), .err_clr(err_clr), .hw_err(hw_err), .busy(busy),
        .en_q(en_q), .ms_q(ms_q), .err_q(err_q)
    );

    sflag_irq u_irq (
        .clk(clk), .rst_n(rst_n), .ien_wr(ien_wr), .ien_data(ien_data),
        .err_q(err_q), .err_en(err_en), .ien_q(ien), .err_irq(err_irq)
    );

    // assemble the status word from the flags and busy
    always_comb begin
        status = '0;
        status[STAT_EN_POS]   = en_q;
        status[STAT_MS_POS]   = ms_q;
        status[STAT_BUSY_POS] = busy;
        for (int i = 0; i < NERR; i++) status[ERR_STAT_POS[i]] = err_q[i];
    end

    // R7
    busy_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[STAT_BUSY_POS] == busy);
endmodule

// File: tb/tb_sflag_top.sv
`timescale 1ns/1ps
module tb_sflag_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_wr = 1'b0;
    logic [15:0] req_data = '0;
    logic        ien_wr = 1'b0;
    logic [3:0]  ien_data = '0;
    logic [5:0]  hw_err = '0;
    logic [5:0]  err_en = '0;
    logic        busy = 1'b0;
    logic [15:0] status;
    logic [3:0]  ien;
    logic        err_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    bit       m_en, m_ms;
    bit [5:0] m_err;
    bit [3:0] m_ien;

    // request bit positions and status positions per error index
    int clr_pos[6]  = '{8, 9, 10, 11, 4, 6};
    int set_pos[6]  = '{12, 13, 14, 15, 5, 7};
    int stat_pos[6] = '{8, 9, 10, 11, 12, 14};

    always #2.5 clk = ~clk;

    sflag_top dut (.*);

    function automatic logic [15:0] exp_status();
        logic [15:0] s = '0;
        s[0] = m_en; s[1] = m_ms; s[13] = busy;
        foreach (stat_pos[i]) s[stat_pos[i]] = m_err[i];
        return s;
    endfunction

    task automatic check(string tag);
        logic [15:0] es = exp_status();
        logic        ei = m_ien[2] && ((m_err & err_en) != 0);
        checks++;
        if (status !== es || ien !== m_ien || err_irq !== ei) begin
            errors++;
            $display("FAIL %s: status=%h ien=%h irq=%b expected status=%h ien=%h irq=%b",
                     tag, status, ien, err_irq, es, m_ien, ei);
        end
    endtask

    // apply inputs, compare, advance the model and one clock
    task automatic cyc(string tag, bit w, logic [15:0] d, bit iw, logic [3:0] id,
                       logic [5:0] hw, logic [5:0] ee, bit b);
        bit       n_en, n_ms;
        bit [5:0] n_err;
        req_wr = w; req_data = d; ien_wr = iw; ien_data = id;
        hw_err = hw; err_en = ee; busy = b;
        #1;
        check(tag);
        n_en = m_en; n_ms = m_ms; n_err = m_err;
        if (w) begin
            if (d[1]) n_en = 1;
            if (d[0] && !b) n_en = 0;
            if (d[3]) n_ms = 1;
            if (d[2]) n_ms = 0;
            foreach (set_pos[i]) begin
                if (d[set_pos[i]]) n_err[i] = 1;
                if (d[clr_pos[i]]) n_err[i] = 0;
            end
        end
        n_err |= hw;
        @(posedge clk);
        if (!rst_n) begin
            m_en = 0; m_ms = 0; m_err = '0; m_ien = '0;
        end else begin
            m_en = n_en; m_ms = n_ms; m_err = n_err;
            if (iw) m_ien = id;
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        int n = 0;
        while (!done) begin
            @(posedge clk);
            n++;
            if (n > 100000) begin
                errors++; checks++;
                $display("FAIL watchdog: actual=expired expected=finished");
                finish_run();
            end
        end
    end

    initial begin
        @(negedge clk);
        rst_n = 0;
        // R1: dirty inputs during reset must leave everything cleared
        cyc("R1", 1, 16'hFFAA, 1, 4'hF, 6'h3F, 6'h3F, 0);
        cyc("R1", 0, 0, 0, 0, 0, 6'h3F, 1);
        rst_n = 1;
        cyc("R1", 0, 0, 0, 0, 0, 6'h3F, 0);
        // R2: set enable and master select
        cyc("R2", 1, 16'h000A, 0, 0, 0, 0, 0);
        // R2: set every error flag
        cyc("R2", 1, 16'hF0A0, 0, 0, 0, 0, 0);
        // R10: no write, junk data
        cyc("R10", 0, 16'hFFFF, 0, 0, 0, 0, 0);
        cyc("R10", 0, 16'h5555, 0, 0, 0, 0, 0);
        // R9: interrupt enable write with error line
        cyc("R9", 0, 0, 1, 4'b0100, 0, 0, 0);
        // R8: per-source enables
        cyc("R8", 0, 0, 0, 0, 0, 6'b000001, 0);
        cyc("R8", 0, 0, 0, 0, 0, 6'b100000, 0);
        // R4: clear all errors, enable and master stay
        cyc("R4", 1, 16'h0F50, 0, 0, 0, 6'h3F, 0);
        cyc("R4", 0, 0, 0, 0, 0, 6'h3F, 0);
        // R3: set and clear together, clear wins
        cyc("R3", 1, 16'hFFF0, 0, 0, 0, 6'h3F, 0);
        cyc("R3", 1, 16'h000F, 0, 0, 0, 6'h3F, 0);
        cyc("R3", 0, 0, 0, 0, 0, 6'h3F, 0);
        // R5: hardware events, including against a clear
        cyc("R5", 1, 16'h0F50, 0, 0, 6'b010101, 6'h3F, 0);
        cyc("R5", 1, 16'h0F50, 0, 0, 6'b101010, 6'h3F, 0);
        cyc("R5", 0, 0, 0, 0, 0, 6'h3F, 0);
        // R6 / R7: busy blocks clearing enable
        cyc("R6", 1, 16'h0002, 0, 0, 0, 0, 0);
        cyc("R6", 1, 16'h0001, 0, 0, 0, 0, 1);
        cyc("R7", 1, 16'h0003, 0, 0, 0, 0, 1);
        cyc("R7", 0, 0, 0, 0, 0, 0, 1);
        cyc("R6", 1, 16'h0001, 0, 0, 0, 0, 0);
        cyc("R6", 0, 0, 0, 0, 0, 0, 0);
        // R8: global error enable off masks the output
        cyc("R8", 0, 0, 1, 4'b1011, 6'h01, 6'h3F, 0);
        cyc("R8", 0, 0, 0, 0, 0, 6'h3F, 0);
        // mixed stimulus
        for (int k = 0; k < 400; k++) begin
            cyc("R10", 1'($urandom), 16'($urandom), 1'($urandom_range(0, 3) == 0),
                4'($urandom), 6'($urandom) & 6'($urandom) & 6'($urandom),
                6'($urandom), 1'($urandom));
        end
        finish_run();
    end
endmodule